// File: doc/BRIEF.md
# Per-Core Idle State Controller

This block follows the halt status of the four hardware threads that share one processor core and steps the core through its idle states. While any thread is still running the core is active (C0). When the last running thread halts, the block first spends one cycle on a residency-logging step, with the core still active and a log pulse raised, and only then gates the core clock (C1). From C1 the core can drop further into a power-gated state (C6). A wake request to any thread brings the core back to C0.

The deep state is entered only when two independent tests pass in the same cycle. The countdown to the next expected interrupt must be at least a configured minimum. The core's own recent history of active and clock-gated cycles must also show enough idleness. That history is kept in two saturating counters, and both are halved once per window of counted cycles so that old activity fades. On leaving C6 the power gate is released at once, and the clock stays gated for a fixed number of restore cycles.

Top module: `core_idle_ctrl`

## Requirements
- R1: During and after synchronous reset (rst_n low) the state code is 00, both gate enables are low, log_pulse is low, no thread is marked halted and both history counters are zero.
- R2: In C0 a halt request sets that thread's bit in `halted` on the next clock, and a wake request clears it. Wake wins when both arrive for the same thread in the same cycle.
- R3: When the halted mask would become all ones in C0, the next cycle is a logging step (state code 00, clock not gated, log_pulse high for exactly that one cycle). The cycle after it is C1 (state code 01, clk_gate_en high).
- R4: A wake request during the logging step or in C1 returns the core to C0 (code 00, clk_gate_en low) on the next clock and clears the woken thread's bit.
- R5: In C1 with no wake request, when next_irq_dist >= irq_dist_min and the idle test passes, the next clock enters C6: code 10, pwr_gate_en high, clk_gate_en high.
- R6: With next_irq_dist below irq_dist_min the core stays in C1 whatever its history.
- R7: The idle test passes when idle*16 >= idle_frac_min*(idle+busy), where idle_frac_min counts sixteenths. A core whose history fails it stays in C1 whatever the interrupt distance.
- R8: A wake request in C6 drops pwr_gate_en on the next clock. clk_gate_en stays high and the code stays 10 for RESTORE_CYC cycles (default 4). Then the core is in C0 with the clock ungated.
- R9: The busy counter adds one for each cycle in C0 (including the logging step) and the idle counter adds one for each cycle in C1. Both saturate at 2^HIST_W-1. Every WINDOW-th counted cycle (default 512) halves both counters instead of adding. Cycles in C6 and restore are not counted.
- R10: Outside C0, including the logging step, C1, C6 and restore, halt requests leave `halted` unchanged. Only wake requests clear bits there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | NTHREADS | Per-thread halt request |
| wake_req | input | NTHREADS | Per-thread wake request |
| next_irq_dist | input | DIST_W | Cycles until the next expected interrupt |
| irq_dist_min | input | DIST_W | Minimum interrupt distance for deep entry |
| idle_frac_min | input | 4 | Minimum idle fraction in sixteenths |
| halted | output | NTHREADS | Per-thread halted flags |
| state_code | output | 2 | 00 = C0, 01 = C1, 10 = C6 or restoring |
| clk_gate_en | output | 1 | Core clock gate enable |
| pwr_gate_en | output | 1 | Core power gate enable |
| log_pulse | output | 1 | One-cycle pulse starting residency logging |

## Verification
The bench goes after the interrupt-distance boundary (equal distance must allow entry) and the separate denial by each deep-entry test. A design that tested only one condition or used a strict compare would enter C6 at the wrong cycle. It wakes a thread during the logging step and in C1, where a design that ignored the wake would gate the clock anyway. It checks that a thread's simultaneous halt and wake leaves it running, where a wrong priority would leave a stuck halted bit. It counts the restore cycles on a C6 exit, where an off-by-one ungates the clock a cycle early or late. It also runs long enough in C0 to saturate the busy counter and cross a halving window, so a wrapping counter or missed halving would shift the C6 entry cycle away from the reference model.

// File: rtl/core_idle_pkg.sv
// Shared types for the per-core idle state controller.
// Assumes: the state machine and its top agree on this one encoding.
package core_idle_pkg;
    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_LOG     = 3'd1,
        ST_C1      = 3'd2,
        ST_C6      = 3'd3,
        ST_RESTORE = 3'd4
    } idle_st_t;

    localparam logic [1:0] CODE_C0 = 2'b00;
    localparam logic [1:0] CODE_C1 = 2'b01;
    localparam logic [1:0] CODE_C6 = 2'b10;
endpackage

// File: rtl/thread_tracker.sv
// Per-thread halted flags for one core.
// Halts are accepted only while the core runs; wakes always clear and win
// over a halt in the same cycle. Reports when the next mask is all ones.
module thread_tracker #(
    parameter int NTHREADS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_phase,
    input  logic [NTHREADS-1:0] halt_req,
    input  logic [NTHREADS-1:0] wake_req,
    output logic [NTHREADS-1:0] halted,
    output logic                all_halt_next
);
    logic [NTHREADS-1:0] mask_q;
    logic [NTHREADS-1:0] mask_d;

    // Next mask: accept halts only in the run phase, wake clears last
    always_comb begin
        if (run_phase) mask_d = (mask_q | halt_req) & ~wake_req;
        else           mask_d = mask_q & ~wake_req;
    end

    // Register the halted flags
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign halted        = mask_q;
    assign all_halt_next = run_phase && (&mask_d);

    // R10
    halt_ignored_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_phase |=> ((mask_q & ~$past(mask_q)) == '0));
    // R2
    wake_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req != '0) |=> ((mask_q & $past(wake_req)) == '0));
endmodule

// File: rtl/idle_history.sv
// Saturating busy/idle cycle counters with periodic halving.
// Assumes: cnt_busy and cnt_idle are never high together. Produces the
// idle-fraction test: idle*16 >= frac_min*(idle+busy).
module idle_history #(
    parameter int HIST_W = 8,
    parameter int WINDOW = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cnt_busy,
    input  logic       cnt_idle,
    input  logic [3:0] frac_min,
    output logic       idle_ok
);
    localparam int WIN_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int PW    = HIST_W + 5;
    localparam logic [HIST_W-1:0] HMAX = {HIST_W{1'b1}};
    localparam logic [WIN_W-1:0]  WLAST = WIN_W'(WINDOW - 1);

    logic [HIST_W-1:0] busy_q, idle_q;
    logic [WIN_W-1:0]  win_q;
    logic              counted, wrap;
    logic [PW-1:0]     lhs, rhs;

    assign counted = cnt_busy || cnt_idle;
    assign wrap    = counted && (win_q == WLAST);

    // Window position over counted cycles
    always_ff @(posedge clk) begin
        if (!rst_n)       win_q <= '0;
        else if (wrap)    win_q <= '0;
        else if (counted) win_q <= win_q + 1'b1;
    end

    // Busy and idle counters: halve on wrap, otherwise saturating add
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            idle_q <= '0;
        end else if (wrap) begin
            busy_q <= busy_q >> 1;
            idle_q <= idle_q >> 1;
        end else begin
            if (cnt_busy && busy_q != HMAX) busy_q <= busy_q + 1'b1;
            if (cnt_idle && idle_q != HMAX) idle_q <= idle_q + 1'b1;
        end
    end

    // Fraction compare in sixteenths
    always_comb begin
        lhs = PW'({idle_q, 4'b0000});
        rhs = PW'(frac_min) * (PW'(idle_q) + PW'(busy_q));
    end
    assign idle_ok = (lhs >= rhs);

    // R9
    busy_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_busy && busy_q == HMAX && !wrap) |=> (busy_q == HMAX));
    // R9
    idle_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_idle && idle_q == HMAX && !wrap) |=> (idle_q == HMAX));
    // R9
    frozen_uncounted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !counted |=> ($stable(busy_q) && $stable(idle_q)));
endmodule

// File: rtl/idle_fsm.sv
// Core idle state sequencer: run, logging step, clock-gated, power-gated
// and restore. Assumes: all_halt_next is only asserted in the run state.
// Restore holds the clock gate for RESTORE_CYC cycles after power returns.
module idle_fsm
    import core_idle_pkg::*;
#(
    parameter int RESTORE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       all_halt_next,
    input  logic       any_wake,
    input  logic       deep_ok,
    output idle_st_t   st,
    output logic [1:0] state_code,
    output logic       clk_gate_en,
    output logic       pwr_gate_en,
    output logic       log_pulse
);
    localparam int RC = (RESTORE_CYC < 1) ? 1 : RESTORE_CYC;
    localparam int RW = (RC > 1) ? $clog2(RC) : 1;
    localparam logic [RW-1:0] RLOAD = RW'(RC - 1);

    idle_st_t      st_q, st_d;
    logic [RW-1:0] rcnt_q;

    // Next-state selection
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_RUN:     if (all_halt_next) st_d = ST_LOG;
            ST_LOG:     st_d = any_wake ? ST_RUN : ST_C1;
            ST_C1:      if (any_wake) st_d = ST_RUN;
                        else if (deep_ok) st_d = ST_C6;
            ST_C6:      if (any_wake) st_d = ST_RESTORE;
            ST_RESTORE: if (rcnt_q == '0) st_d = ST_RUN;
            default:    st_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    // Restore countdown, loaded on leaving C6
    always_ff @(posedge clk) begin
        if (!rst_n)                                  rcnt_q <= '0;
        else if (st_q == ST_C6 && st_d == ST_RESTORE) rcnt_q <= RLOAD;
        else if (st_q == ST_RESTORE && rcnt_q != '0)  rcnt_q <= rcnt_q - 1'b1;
    end

    // Output decode from the state register
    always_comb begin
        clk_gate_en = (st_q == ST_C1) || (st_q == ST_C6) || (st_q == ST_RESTORE);
        pwr_gate_en = (st_q == ST_C6);
        log_pulse   = (st_q == ST_LOG);
        case (st_q)
            ST_C1:               state_code = CODE_C1;
            ST_C6, ST_RESTORE:   state_code = CODE_C6;
            default:             state_code = CODE_C0;
        endcase
    end

    assign st = st_q;

    // R5
    pg_needs_cg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_gate_en |-> clk_gate_en);
    // R3
    log_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        log_pulse |=> !log_pulse);
    // R3
    c1_after_log_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_C1 && $past(st_q) != ST_C1) |-> ($past(st_q) == ST_LOG));
    // R5
    c6_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_C6 && $past(st_q) == ST_C1) |-> $past(deep_ok));
    // R8
    power_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_gate_en) |-> clk_gate_en);
endmodule

// File: rtl/core_idle_ctrl.sv
// Top of the per-core idle state controller.
// Combines the thread tracker, the residency history and the sequencer;
// deep entry needs both the interrupt-distance and idle-fraction tests.
module core_idle_ctrl
    import core_idle_pkg::*;
#(
    parameter int NTHREADS    = 4,
    parameter int DIST_W      = 16,
    parameter int HIST_W      = 8,
    parameter int WINDOW      = 512,
    parameter int RESTORE_CYC = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NTHREADS-1:0] halt_req,
    input  logic [NTHREADS-1:0] wake_req,
    input  logic [DIST_W-1:0]   next_irq_dist,
    input  logic [DIST_W-1:0]   irq_dist_min,
    input  logic [3:0]          idle_frac_min,
    output logic [NTHREADS-1:0] halted,
    output logic [1:0]          state_code,
    output logic                clk_gate_en,
    output logic                pwr_gate_en,
    output logic                log_pulse
);
    idle_st_t st;
    logic     all_halt_next, idle_ok, deep_ok, far_enough;

    thread_tracker #(.NTHREADS(NTHREADS)) u_threads (
        .clk           (clk),
        .rst_n         (rst_n),
        .run_phase     (st == ST_RUN),
        .halt_req      (halt_req),
        .wake_req      (wake_req),
        .halted        (halted),
        .all_halt_next (all_halt_next)
    );

    idle_history #(.HIST_W(HIST_W), .WINDOW(WINDOW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_busy ((st == ST_RUN) || (st == ST_LOG)),
        .cnt_idle (st == ST_C1),
        .frac_min (idle_frac_min),
        .idle_ok  (idle_ok)
    );

    // Both deep-entry tests must pass together
    assign far_enough = (next_irq_dist >= irq_dist_min);
    assign deep_ok    = far_enough && idle_ok;

    idle_fsm #(.RESTORE_CYC(RESTORE_CYC)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .all_halt_next (all_halt_next),
        .any_wake      (|wake_req),
        .deep_ok       (deep_ok),
        .st            (st),
        .state_code    (state_code),
        .clk_gate_en   (clk_gate_en),
        .pwr_gate_en   (pwr_gate_en),
        .log_pulse     (log_pulse)
    );

    // R6
    near_irq_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == CODE_C1 && !far_enough && wake_req == '0) |=> (state_code == CODE_C1));
    // R7
    busy_history_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == CODE_C1 && !idle_ok && wake_req == '0) |=> (state_code == CODE_C1));
    // R4
    wake_from_c1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == CODE_C1 && wake_req != '0) |=> (state_code == CODE_C0 && !clk_gate_en));
endmodule

// File: tb/core_idle_ctrl_tb.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module core_idle_ctrl_tb;
    localparam int NT = 4, DW = 16, HW = 8, WIN = 512, RC = 4;
    localparam int HMAXI = (1 << HW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] halt_req = '0, wake_req = '0;
    logic [DW-1:0] next_irq_dist = '0, irq_dist_min = 16'd100;
    logic [3:0]    idle_frac_min = 4'd0;
    logic [NT-1:0] halted;
    logic [1:0]    state_code;
    logic          clk_gate_en, pwr_gate_en, log_pulse;

    int checks = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    bit compare_on = 1'b0;

    // Model state: 0 run, 1 log, 2 C1, 3 C6, 4 restore
    int m_st = 0, m_busy = 0, m_idle = 0, m_w = 0, m_r = 0;
    logic [NT-1:0] m_h = '0;

    always #5 clk = ~clk;

    core_idle_ctrl #(.NTHREADS(NT), .DIST_W(DW), .HIST_W(HW), .WINDOW(WIN),
                     .RESTORE_CYC(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wake_req(wake_req),
        .next_irq_dist(next_irq_dist), .irq_dist_min(irq_dist_min),
        .idle_frac_min(idle_frac_min), .halted(halted), .state_code(state_code),
        .clk_gate_en(clk_gate_en), .pwr_gate_en(pwr_gate_en), .log_pulse(log_pulse));

    // Reference model update on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_busy = 0; m_idle = 0; m_w = 0; m_r = 0; m_h = '0;
        end else begin
            bit deep;
            logic [NT-1:0] nh;
            deep = (next_irq_dist >= irq_dist_min) &&
                   (m_idle * 16 >= int'(idle_frac_min) * (m_idle + m_busy));
            if (m_st <= 2) begin
                if (m_w == WIN - 1) begin
                    m_busy = m_busy / 2; m_idle = m_idle / 2; m_w = 0;
                end else begin
                    if (m_st == 2) m_idle = (m_idle < HMAXI) ? m_idle + 1 : HMAXI;
                    else           m_busy = (m_busy < HMAXI) ? m_busy + 1 : HMAXI;
                    m_w++;
                end
            end
            nh = (m_st == 0) ? ((m_h | halt_req) & ~wake_req) : (m_h & ~wake_req);
            case (m_st)
                0: if (nh == '1) m_st = 1;
                1: m_st = (wake_req != '0) ? 0 : 2;
                2: if (wake_req != '0) m_st = 0; else if (deep) m_st = 3;
                3: if (wake_req != '0) begin m_st = 4; m_r = RC - 1; end
                default: if (m_r == 0) m_st = 0; else m_r--;
            endcase
            m_h = nh;
        end
    end

    // Compare every cycle, away from the rising edge
    always @(negedge clk) begin
        cycles++;
        if (compare_on) begin
            logic [1:0] ec;
            ec = (m_st == 2) ? 2'b01 : (m_st >= 3) ? 2'b10 : 2'b00;
            checks++;
            if (state_code !== ec || clk_gate_en !== (m_st >= 2) ||
                pwr_gate_en !== (m_st == 3) || log_pulse !== (m_st == 1) ||
                halted !== m_h) begin
                errors++;
                $display("FAIL %s model: got code=%b cg=%b pg=%b log=%b h=%b exp code=%b cg=%b pg=%b log=%b h=%b",
                         cur_req, state_code, clk_gate_en, pwr_gate_en, log_pulse, halted,
                         ec, (m_st >= 2), (m_st == 3), (m_st == 1), m_h);
            end
        end
    end

    task automatic chk(input string req, input logic [1:0] c, input logic cg, input logic pg);
        checks++;
        if (state_code !== c || clk_gate_en !== cg || pwr_gate_en !== pg) begin
            errors++;
            $display("FAIL %s: got code=%b cg=%b pg=%b exp code=%b cg=%b pg=%b",
                     req, state_code, clk_gate_en, pwr_gate_en, c, cg, pg);
        end
    endtask

    task automatic chk_bits(input string req, input logic [NT-1:0] h, input logic lp);
        checks++;
        if (halted !== h || log_pulse !== lp) begin
            errors++;
            $display("FAIL %s: got halted=%b log=%b exp halted=%b log=%b",
                     req, halted, log_pulse, h, lp);
        end
    endtask

    // Drive one cycle of requests, then wait for the result
    task automatic step(input logic [NT-1:0] h, input logic [NT-1:0] w);
        halt_req = h; wake_req = w;
        @(negedge clk);
        halt_req = '0; wake_req = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", 2'b00, 1'b0, 1'b0);
        chk_bits("R1", 4'b0000, 1'b0);
        rst_n = 1'b1;
        compare_on = 1'b1;
        @(negedge clk);
        chk("R1", 2'b00, 1'b0, 1'b0);

        // R2: halts and wakes in C0, wake wins
        cur_req = "R2";
        step(4'b0001, 4'b0000); chk_bits("R2", 4'b0001, 1'b0);
        step(4'b0010, 4'b0010); chk_bits("R2", 4'b0001, 1'b0);
        step(4'b0100, 4'b0001); chk_bits("R2", 4'b0100, 1'b0);
        step(4'b0011, 4'b0000); chk_bits("R2", 4'b0111, 1'b0);

        // R3: last halt gives logging step then C1
        cur_req = "R3";
        step(4'b1000, 4'b0000);
        chk("R3", 2'b00, 1'b0, 1'b0); chk_bits("R3", 4'b1111, 1'b1);
        step('0, '0);
        chk("R3", 2'b01, 1'b1, 1'b0); chk_bits("R3", 4'b1111, 1'b0);

        // R6: interrupt too close, stays in C1
        cur_req = "R6";
        repeat (10) step('0, '0);
        chk("R6", 2'b01, 1'b1, 1'b0);

        // R4: wake in C1, then wake during the logging step
        cur_req = "R4";
        step('0, 4'b0010);
        chk("R4", 2'b00, 1'b0, 1'b0); chk_bits("R4", 4'b1101, 1'b0);
        step(4'b0010, '0); chk_bits("R4", 4'b1111, 1'b1);
        step('0, 4'b1000);
        chk("R4", 2'b00, 1'b0, 1'b0); chk_bits("R4", 4'b0111, 1'b0);

        // R5: distance equal to the minimum passes, fraction zero passes
        cur_req = "R5";
        next_irq_dist = 16'd100;
        step(4'b1000, '0);
        step('0, '0); chk("R5", 2'b01, 1'b1, 1'b0);
        step('0, '0); chk("R5", 2'b10, 1'b1, 1'b1);

        // R8 and R10: restore sequence, halts ignored while restoring
        cur_req = "R8";
        step('0, 4'b0100);
        chk("R8", 2'b10, 1'b1, 1'b0); chk_bits("R8", 4'b1011, 1'b0);
        cur_req = "R10";
        step(4'b0100, '0); chk_bits("R10", 4'b1011, 1'b0);
        chk("R8", 2'b10, 1'b1, 1'b0);
        cur_req = "R8";
        step('0, '0); step('0, '0);
        chk("R8", 2'b10, 1'b1, 1'b0);
        step('0, '0);
        chk("R8", 2'b00, 1'b0, 1'b0);

        // R7: long busy run saturates history, strict fraction blocks C6
        cur_req = "R7";
        next_irq_dist = 16'd5000;
        idle_frac_min = 4'd15;
        repeat (300) step('0, '0);
        step(4'b0100, '0);
        chk_bits("R7", 4'b1111, 1'b1);
        repeat (30) step('0, '0);
        chk("R7", 2'b01, 1'b1, 1'b0);

        // R9: looser fraction, entry timing follows the counters
        cur_req = "R9";
        idle_frac_min = 4'd2;
        repeat (300) step('0, '0);
        chk("R9", 2'b10, 1'b1, 1'b1);
        step('0, 4'b1111);
        repeat (RC) step('0, '0);
        chk("R9", 2'b00, 1'b0, 1'b0);
        chk_bits("R9", 4'b0000, 1'b0);

        // Mixed traffic across a halving window
        repeat (600) begin
            step(4'b1111, '0);
            repeat (5) step('0, '0);
            step('0, 4'b0001);
        end
        repeat (3) step('0, '0);
        finish_run();
    end
endmodule